// File: doc/BRIEF.md
# Fetch Jump-Replay Controller

This controller sits beside the front stages of an instruction fetch pipeline whose storage banks are clocked at half the core rate, with alternate banks on opposite phases of that half-rate clock. Each cycle it looks at the request entering stage S0 and compares it with the request held in stage S1. A non-sequential jump can aim a request at a bank that cannot take a new access in that cycle. The controller detects this and, one cycle later, raises kill and replay strobes. These strobes tell the surrounding pipeline to hold S1 for one more cycle, or to reissue the S2 request twice. Either way, no request is lost.

The data-bank path and the tag-bank path are judged independently, and each has its own set of strobes. Addresses are word addresses, where one word is one fetch beat. The data bank is chosen by the low bits of the word address, and bank phase follows the lowest of those bits. The tag bank is chosen by the lowest set-index bit, which is the first bit above the word-in-line bits. Each path keeps a repeat-parity flag. The flag records whether the address in S1 has been requested an even number of times in a row, and it swaps which relationships are harmful. The strobes are plain level controls with no handshake, and the block has no back-pressure of its own.

Top module: `fetch_replay_ctrl`

## Requirements
- R1: After reset, all six strobes are 0 and both parity flags are in odd mode.
- R2: With the defaults (16-bit word address, 4 data banks, 8 words per line), the data bank is addr[1:0], its phase is addr[0], the tag bank is addr[3], and the tag path's line identity is addr[15:3].
- R3: In odd mode, a request whose data bank is on the opposite phase from the S1 bank causes no strobe. A request whose tag bank differs from the S1 tag bank also causes no strobe.
- R4: In odd mode, a request to a different data bank on the same phase causes the single-hold action. In the cycle after the request, kill_s1 and replay_s1 are both 1, for exactly one cycle.
- R5: In odd mode, a request to the same bank as S1 causes the single-hold action when S1 is not valid.
- R6: In odd mode, a request to the same bank as a valid S1 causes the double-replay action. Starting the cycle after the request, kill_s1 and replay_s2 are both 1 for exactly two consecutive cycles.
- R7: In even mode, an opposite-phase request causes the single-hold action. Same-phase and same-bank requests cause no strobe.
- R8: An evaluated request toggles the path's parity flag when S1 is valid and holds the same address (the same line on the tag path). Any other evaluated request returns the flag to odd mode.
- R9: While a path's strobes are active, requests on that path are not evaluated and its parity flag does not change.
- R10: When s0_valid is 0, no evaluation takes place and no new strobe follows.
- R11: The data path and the tag path decide independently. The tag path handles a same-tag-bank request like a same-bank request.
- R12: replay_s1 and replay_s2 of one path are never 1 together, and each replay strobe comes with kill_s1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s0_valid | input | 1 | Request present in S0 |
| s0_addr | input | ADDR_W | S0 word address |
| s1_valid | input | 1 | Request present in S1 |
| s1_addr | input | ADDR_W | S1 word address |
| dat_kill_s1 | output | 1 | Data path: invalidate the S1 request |
| dat_replay_s1 | output | 1 | Data path: hold S1 for one more cycle |
| dat_replay_s2 | output | 1 | Data path: reissue the S2 request |
| tag_kill_s1 | output | 1 | Tag path: invalidate the S1 request |
| tag_replay_s1 | output | 1 | Tag path: hold S1 for one more cycle |
| tag_replay_s2 | output | 1 | Tag path: reissue the S2 request |

## Verification
The assertions check the strobe shapes on every cycle. A single hold lasts exactly one cycle, and a double replay lasts exactly two. The two replay kinds never overlap. Without a request no strobe starts, and the parity flag stays frozen while it is not being updated. Only the bench scenarios can show that each bank relationship, in each parity mode, picks the right action. They also show that the parity flag follows repeated addresses, that suppression hides requests during a replay, and that the two paths stay apart. The bench compares every cycle's strobes against a model of the rules.

// File: rtl/jr_pkg.sv
package jr_pkg;
  // relationship of the S0 bank to the S1 bank
  typedef enum logic [1:0] {
    REL_OPP_PHASE,
    REL_SAME_PHASE,
    REL_SAME_BANK
  } jr_rel_e;

  // action chosen for one evaluated request
  typedef enum logic [1:0] {
    ACT_NONE,
    ACT_HOLD1,
    ACT_REPLAY2
  } jr_act_e;

  // sequencer state; outputs are decoded from it
  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_HOLD1,
    SQ_REP_A,
    SQ_REP_B
  } jr_state_e;
endpackage

// File: rtl/jr_classify.sv
module jr_classify
  import jr_pkg::*;
#(
  parameter int SEL_W = 2
) (
  input  logic [SEL_W-1:0] sel_new,
  input  logic [SEL_W-1:0] sel_old,
  input  logic             old_valid,
  input  logic             even_mode,
  output jr_rel_e          rel,
  output jr_act_e          act
);
  logic phase_differs;
  logic bank_differs;

  assign phase_differs = sel_new[0] != sel_old[0];
  assign bank_differs  = sel_new != sel_old;

  always_comb begin
    if (phase_differs)     rel = REL_OPP_PHASE;
    else if (bank_differs) rel = REL_SAME_PHASE;
    else                   rel = REL_SAME_BANK;
  end

  // odd mode: only the same-phase relations hurt; even mode swaps this
  always_comb begin
    act = ACT_NONE;
    unique case (rel)
      REL_OPP_PHASE:  act = even_mode ? ACT_HOLD1 : ACT_NONE;
      REL_SAME_PHASE: act = even_mode ? ACT_NONE  : ACT_HOLD1;
      default:        act = even_mode ? ACT_NONE
                          : (old_valid ? ACT_REPLAY2 : ACT_HOLD1);
    endcase
  end
endmodule

// File: rtl/jr_parity.sv
module jr_parity #(
  parameter int KEY_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd,
  input  logic [KEY_W-1:0] key_new,
  input  logic [KEY_W-1:0] key_old,
  input  logic             old_valid,
  output logic             even_mode
);
  logic repeat_hit;
  assign repeat_hit = old_valid && (key_new == key_old);

  always_ff @(posedge clk) begin
    if (!rst_n)   even_mode <= 1'b0;
    else if (upd) even_mode <= repeat_hit ? ~even_mode : 1'b0;
  end

  a_r8_clear_on_new_address: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !repeat_hit) |=> !even_mode);
  a_r9_flag_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(even_mode));
endmodule

// File: rtl/jr_sequencer.sv
module jr_sequencer
  import jr_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    s0_valid,
  input  jr_act_e act,
  output logic    eval,
  output logic    kill_s1,
  output logic    replay_s1,
  output logic    replay_s2
);
  jr_state_e st, st_nx;

  assign eval = (st == SQ_IDLE) && s0_valid;

  always_comb begin
    st_nx = st;
    unique case (st)
      SQ_IDLE: begin
        if (eval) begin
          unique case (act)
            ACT_HOLD1:   st_nx = SQ_HOLD1;
            ACT_REPLAY2: st_nx = SQ_REP_A;
            default:     st_nx = SQ_IDLE;
          endcase
        end
      end
      SQ_HOLD1: st_nx = SQ_IDLE;
      SQ_REP_A: st_nx = SQ_REP_B;
      default:  st_nx = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= SQ_IDLE;
    else        st <= st_nx;
  end

  assign kill_s1   = st != SQ_IDLE;
  assign replay_s1 = st == SQ_HOLD1;
  assign replay_s2 = (st == SQ_REP_A) || (st == SQ_REP_B);

  a_r10_no_request_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (!kill_s1 && !s0_valid) |=> !kill_s1);
  a_r4_hold_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    replay_s1 |=> !kill_s1);
  a_r6_replay_second_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(replay_s2) |=> replay_s2);
  a_r6_replay_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (replay_s2 && $past(replay_s2)) |=> !kill_s1);
  a_r12_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(replay_s1 && replay_s2));
endmodule

// File: rtl/jr_path.sv
module jr_path
  import jr_pkg::*;
#(
  parameter int SEL_W = 2,
  parameter int KEY_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s0_valid,
  input  logic [SEL_W-1:0] s0_sel,
  input  logic [KEY_W-1:0] s0_key,
  input  logic             s1_valid,
  input  logic [SEL_W-1:0] s1_sel,
  input  logic [KEY_W-1:0] s1_key,
  output logic             kill_s1,
  output logic             replay_s1,
  output logic             replay_s2
);
  logic    even_mode;
  logic    eval;
  jr_rel_e rel;
  jr_act_e act;

  jr_classify #(.SEL_W(SEL_W)) u_cls (
    .sel_new  (s0_sel),
    .sel_old  (s1_sel),
    .old_valid(s1_valid),
    .even_mode(even_mode),
    .rel      (rel),
    .act      (act)
  );

  jr_parity #(.KEY_W(KEY_W)) u_par (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd      (eval),
    .key_new  (s0_key),
    .key_old  (s1_key),
    .old_valid(s1_valid),
    .even_mode(even_mode)
  );

  jr_sequencer u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .s0_valid (s0_valid),
    .act      (act),
    .eval     (eval),
    .kill_s1  (kill_s1),
    .replay_s1(replay_s1),
    .replay_s2(replay_s2)
  );

  a_r3_opposite_phase_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (eval && !even_mode && rel == REL_OPP_PHASE) |=> !kill_s1);
endmodule

// File: rtl/fetch_replay_ctrl.sv
module fetch_replay_ctrl #(
  parameter int ADDR_W     = 16,
  parameter int NBANK      = 4,
  parameter int LINE_WORDS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s0_valid,
  input  logic [ADDR_W-1:0] s0_addr,
  input  logic              s1_valid,
  input  logic [ADDR_W-1:0] s1_addr,
  output logic              dat_kill_s1,
  output logic              dat_replay_s1,
  output logic              dat_replay_s2,
  output logic              tag_kill_s1,
  output logic              tag_replay_s1,
  output logic              tag_replay_s2
);
  localparam int BANK_W     = $clog2(NBANK);
  localparam int LINE_SHIFT = $clog2(LINE_WORDS);
  localparam int LINE_W     = ADDR_W - LINE_SHIFT;

  // data banks: selected by the low word bits, phase by bit 0
  jr_path #(.SEL_W(BANK_W), .KEY_W(ADDR_W)) u_dat (
    .clk      (clk),
    .rst_n    (rst_n),
    .s0_valid (s0_valid),
    .s0_sel   (s0_addr[BANK_W-1:0]),
    .s0_key   (s0_addr),
    .s1_valid (s1_valid),
    .s1_sel   (s1_addr[BANK_W-1:0]),
    .s1_key   (s1_addr),
    .kill_s1  (dat_kill_s1),
    .replay_s1(dat_replay_s1),
    .replay_s2(dat_replay_s2)
  );

  // tag banks: two, selected by the lowest set-index bit
  jr_path #(.SEL_W(1), .KEY_W(LINE_W)) u_tag (
    .clk      (clk),
    .rst_n    (rst_n),
    .s0_valid (s0_valid),
    .s0_sel   (s0_addr[LINE_SHIFT]),
    .s0_key   (s0_addr[ADDR_W-1:LINE_SHIFT]),
    .s1_valid (s1_valid),
    .s1_sel   (s1_addr[LINE_SHIFT]),
    .s1_key   (s1_addr[ADDR_W-1:LINE_SHIFT]),
    .kill_s1  (tag_kill_s1),
    .replay_s1(tag_replay_s1),
    .replay_s2(tag_replay_s2)
  );
endmodule

// File: tb/fetch_replay_ctrl_test.sv
module fetch_replay_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        s0_valid = 1'b0, s1_valid = 1'b0;
  logic [15:0] s0_addr = '0, s1_addr = '0;
  logic dk, dr1, dr2, tk, tr1, tr2;

  int checks = 0;
  int fails  = 0;

  logic [5:0] exp_q[$];
  string      tag_q[$];

  // model state per path: 0 idle, 1 hold, 2 replay A, 3 replay B
  int  d_st = 0, t_st = 0;
  bit  d_even = 0, t_even = 0;

  always #2 clk = ~clk;

  fetch_replay_ctrl uut (
    .clk(clk), .rst_n(rst_n),
    .s0_valid(s0_valid), .s0_addr(s0_addr),
    .s1_valid(s1_valid), .s1_addr(s1_addr),
    .dat_kill_s1(dk), .dat_replay_s1(dr1), .dat_replay_s2(dr2),
    .tag_kill_s1(tk), .tag_replay_s1(tr1), .tag_replay_s2(tr2)
  );

  // 0 none, 1 hold once, 2 replay twice
  function automatic int choose(bit opp, bit same_bank, bit even, bit v1);
    if (opp) return even ? 1 : 0;
    if (!same_bank) return even ? 0 : 1;
    if (even) return 0;
    return v1 ? 2 : 1;
  endfunction

  task automatic advance(inout int st, inout bit even, input bit v0, input bit v1,
                         input bit opp, input bit same_bank, input bit key_eq);
    int act;
    if (st == 0) begin
      if (v0) begin
        act = choose(opp, same_bank, even, v1);
        even = (v1 && key_eq) ? !even : 1'b0;
        st = act;
      end
    end else if (st == 2) st = 3;
    else st = 0;
  endtask

  task automatic step(input bit v0, input logic [15:0] a0, input bit v1,
                      input logic [15:0] a1, input string req);
    @(negedge clk);
    s0_valid = v0; s0_addr = a0; s1_valid = v1; s1_addr = a1;
    advance(d_st, d_even, v0, v1, a0[0] != a1[0], a0[1:0] == a1[1:0], a0 == a1);
    advance(t_st, t_even, v0, v1, a0[3] != a1[3], a0[3] == a1[3], a0[15:3] == a1[15:3]);
    exp_q.push_back({d_st != 0, d_st == 1, d_st >= 2, t_st != 0, t_st == 1, t_st >= 2});
    tag_q.push_back(req);
  endtask

  // monitor: one expected vector per cycle, sampled just after the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        logic [5:0] e;
        string      t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if ({dk, dr1, dr2, tk, tr1, tr2} !== e) begin
          fails++;
          $display("FAIL %s: got %b expected %b", t, {dk, dr1, dr2, tk, tr1, tr2}, e);
        end
      end
    end
  end

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    checks++;
    if ({dk, dr1, dr2, tk, tr1, tr2} !== 6'b0) begin
      fails++;
      $display("FAIL R1: got %b expected %b", {dk, dr1, dr2, tk, tr1, tr2}, 6'b0);
    end
    // R10: no request
    step(0, 16'h0004, 1, 16'h0000, "R10");
    step(0, 16'h0000, 1, 16'h0000, "R10");
    // R3: sequential word, opposite phase, line change also opposite tag bank
    step(1, 16'h0008, 1, 16'h0007, "R3");
    step(0, 16'h0000, 0, 16'h0000, "R3");
    // R4 / R11: data same phase other bank, tag opposite bank
    step(1, 16'h000D, 1, 16'h0007, "R4");
    step(0, 16'h0000, 0, 16'h0000, "R4");
    step(0, 16'h0000, 0, 16'h0000, "R11");
    // R5: same data bank, S1 invalid; tag same bank invalid S1
    step(1, 16'h0104, 0, 16'h0010, "R5");
    step(0, 16'h0000, 0, 16'h0000, "R5");
    // R6 / R2: same data bank with valid S1, upper bits differ
    step(1, 16'h1235, 1, 16'h0005, "R6");
    step(1, 16'h0001, 1, 16'h0003, "R9");
    step(1, 16'h0001, 1, 16'h0003, "R9");
    step(0, 16'h0000, 0, 16'h0000, "R6");
    step(0, 16'h0000, 0, 16'h0000, "R2");
    // R8 / R7: repeat an address, then opposite phase in even mode
    step(1, 16'h0020, 0, 16'h0000, "R8");
    step(0, 16'h0000, 0, 16'h0000, "R8");
    step(1, 16'h0020, 1, 16'h0020, "R8");
    step(0, 16'h0000, 0, 16'h0000, "R8");
    step(0, 16'h0000, 0, 16'h0000, "R8");
    step(1, 16'h0021, 1, 16'h0020, "R7");
    step(0, 16'h0000, 0, 16'h0000, "R7");
    step(1, 16'h0023, 1, 16'h0021, "R12");
    step(0, 16'h0000, 0, 16'h0000, "R12");
    // mixed stream over a small address pool
    for (int i = 0; i < 400; i++) begin
      logic [15:0] a0, a1;
      a1 = 16'($urandom_range(0, 31));
      a0 = ($urandom_range(0, 3) == 0) ? a1 : 16'($urandom_range(0, 31));
      step($urandom_range(0, 4) != 0, a0, $urandom_range(0, 5) != 0, a1, "R7 R8 R9 R11 R12");
    end
    step(0, 16'h0000, 0, 16'h0000, "R10");
    step(0, 16'h0000, 0, 16'h0000, "R10");
    step(0, 16'h0000, 0, 16'h0000, "R10");
    @(posedge clk);
    @(posedge clk);
    #2;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule